// File: doc/BRIEF.md
# Indexed register and memory window

This block is the memory-mapped register front end of a display controller. A simple bus (address, write data, size code, read and write strobes) reaches a 16 KiB register space. Two locations form an indirect path. The index register at byte address 0x000 holds a 32-bit pointer. The four-byte data window at 0x004 to 0x007 forwards each access to the target that the pointer selects.

When pointer bit 31 is set, a window access goes out on the memory port. The access is little-endian, and it is made only if the whole access fits inside the memory. When bit 31 is clear, the window forwards the access into the register space itself, one level deep.

Every 32-bit register accepts byte, halfword and word accesses at any byte offset. The register space also contains:
- a bank of scratch registers;
- constant status words;
- a read-only mirror of configuration space, fetched through a small read port.

A second decode mode aliases the lowest 256 bytes of the register space for an I/O-style path.

Top module: `ixw_window`

## Requirements
- R1: The index register at 0x000 resets to 0. A word write stores all 32 bits, and a word read returns them.
- R2: With index bit 31 set, any access to 0x004..0x007 goes to memory at address index[30:0]; the window byte offset is not added. mem_size_o carries the size code. Data is right-justified and little-endian: data bits [8k+7:8k] belong to memory byte address+k.
- R3: A window memory access is issued (mem_rd_o or mem_wr_o high) only if index[30:0] + n <= MEM_BYTES, where n is the access size in bytes. Otherwise a read returns 0 and a write leaves the memory port idle.
- R4: With index bit 31 clear, a window access is performed on register address index + (address & 3), with the same size.
- R5: A forwarded access whose target lies in 0x004..0x007 or at or above 0x4000 reads 0 and writes nothing.
- R6: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The register access uses byte offset address[1:0]. A read returns bits [8*offset +: 8n] of the word, right-justified and zero-filled. A write replaces only those bits. Bits that would fall above bit 31 are dropped.
- R7: Byte addresses 0xF00..0xFFF read the configuration word that cfg_rdata_i returns for word index cfg_addr_o = address[7:2]. Writes there change nothing and raise no rf_wr_o.
- R8: Address 0x150 always reads 5, and addresses 0xE40 and 0x1740 always read 64. Writes to these addresses are ignored.
- R9: With io_sel_i high, only addr_i[7:0] is decoded and addr_i[13:8] is treated as zero.
- R10: Any other register address reads 0 and ignores writes.
- R11: N_SCR scratch registers at 0x010 + 4k reset to 0 and are read/write. A write to the index or a scratch register raises rf_wr_o in its cycle. In that cycle, rf_addr_o carries the word-aligned address and rf_wdata_o the merged word.
- R12: rdata_o is valid combinationally in the cycle rd_i is high and is 0 while rd_i is low. Writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sel_i | input | 1 | Decode only the low 8 address bits |
| addr_i | input | 14 | Register byte address |
| wdata_i | input | 32 | Write data, right-justified |
| size_i | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data, right-justified |
| rf_wr_o | output | 1 | Register-file write commit |
| rf_addr_o | output | 14 | Word-aligned register address of the write |
| rf_wdata_o | output | 32 | Merged register word being written |
| cfg_addr_o | output | 6 | Configuration mirror word index |
| cfg_rdata_i | input | 32 | Configuration mirror word |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | MEM_AW | Memory byte address |
| mem_size_o | output | 2 | Memory access size code |
| mem_wdata_o | output | 32 | Memory write data, little-endian, right-justified |
| mem_rdata_i | input | 32 | Memory read data, little-endian, right-justified |

## Verification
Directed cases cover the following:
- reset values and the constant status words;
- sub-word merges at every offset, including a halfword at offset 3 that is cut at bit 31;
- memory accesses that end exactly at the memory limit and one byte past it;
- forwarding that lands on the window itself or past the end of the register space;
- the I/O alias, tried against the same address without it.

Random traffic then varies the index between memory pointers near the bound and register pointers into every region. It mixes sizes, window offsets and decode modes.

Each read is compared with a reference model, and each write with the expected memory and register-file strobes. This separates a wrong offset (window offset added on memory, or dropped on forwarding) from a wrong bound or a wrong lane merge.

// File: rtl/ixw_pkg.sv
package ixw_pkg;
  localparam int unsigned RAW   = 14;
  localparam int unsigned IO_AW = 8;

  localparam logic [RAW-1:0] A_INDEX    = 14'h0000;
  localparam logic [RAW-1:0] A_WIN      = 14'h0004;
  localparam logic [RAW-1:0] A_SCR      = 14'h0010;
  localparam logic [RAW-1:0] A_MC_STAT  = 14'h0150;
  localparam logic [RAW-1:0] A_ENG_STAT = 14'h0E40;
  localparam logic [RAW-1:0] A_GUI_STAT = 14'h1740;
  localparam logic [RAW-1:0] A_CFG_LO   = 14'h0F00;
  localparam logic [RAW-1:0] A_CFG_HI   = 14'h0FFC;

  localparam logic [31:0] MC_STAT_VAL   = 32'd5;
  localparam logic [31:0] FIFO_FREE_VAL = 32'd64;

  function automatic logic [2:0] size_bytes(logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ixw_sub_word.sv
module ixw_sub_word
  import ixw_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic [1:0]  offs_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rd_o,
  output logic [31:0] merged_o
);
  logic [4:0]  sh;
  logic [31:0] m;
  logic [31:0] lane_m;

  always_comb begin
    sh       = {offs_i, 3'b000};
    m        = size_mask(size_i);
    rd_o     = (word_i >> sh) & m;
    lane_m   = m << sh;  // lanes past bit 31 fall off
    merged_o = (word_i & ~lane_m) | ((wdata_i << sh) & lane_m);
  end
endmodule

// File: rtl/ixw_mem_gate.sv
module ixw_mem_gate
  import ixw_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 16 * 1024 * 1024,
  localparam int unsigned MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  input  logic [30:0]       ptr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  logic [32:0] end_a;
  logic        fits;

  always_comb begin
    end_a = {2'b00, ptr_i} + 33'(size_bytes(size_i));
    fits  = end_a <= 33'(MEM_BYTES);
  end

  assign mem_rd_o    = req_rd_i & fits;
  assign mem_wr_o    = req_wr_i & fits;
  assign mem_addr_o  = ptr_i[MEM_AW-1:0];
  assign mem_size_o  = size_i;
  assign mem_wdata_o = wdata_i & size_mask(size_i);
  assign rdata_o     = mem_rd_o ? (mem_rdata_i & size_mask(size_i)) : 32'h0;

  // R3
  mem_in_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |->
      (33'(mem_addr_o) + 33'(size_bytes(mem_size_o)) <= 33'(MEM_BYTES)));
endmodule

// File: rtl/ixw_reg_space.sv
module ixw_reg_space
  import ixw_pkg::*;
#(
  parameter int unsigned N_SCR = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [31:0]    acc_addr_i,
  input  logic           acc_rd_i,
  input  logic           acc_wr_i,
  input  logic [1:0]     size_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic [31:0]    index_o,
  output logic           rf_wr_o,
  output logic [RAW-1:0] rf_addr_o,
  output logic [31:0]    rf_wdata_o,
  output logic [5:0]     cfg_addr_o,
  input  logic [31:0]    cfg_rdata_i
);
  logic              in_space;
  logic [RAW-1:0]    wa;
  logic              hit_idx, hit_cfg, hit_mc, hit_fifo;
  logic [N_SCR-1:0]  hit_scr;
  logic [31:0]       idx_q;
  logic [N_SCR-1:0][31:0] scr_q;
  logic [31:0]       word, rd_w, merged;

  assign in_space = acc_addr_i[31:RAW] == '0;
  assign wa       = {acc_addr_i[RAW-1:2], 2'b00};
  assign hit_idx  = in_space && (wa == A_INDEX);
  assign hit_mc   = in_space && (wa == A_MC_STAT);
  assign hit_fifo = in_space && ((wa == A_ENG_STAT) || (wa == A_GUI_STAT));
  assign hit_cfg  = in_space && (wa >= A_CFG_LO) && (wa <= A_CFG_HI);

  for (genvar g = 0; g < N_SCR; g++) begin : g_scr
    assign hit_scr[g] = in_space && (wa == A_SCR + RAW'(4 * g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      scr_q[g] <= '0;
      else if (acc_wr_i && hit_scr[g])  scr_q[g] <= merged;
    end
  end

  // window and unmapped words fall through to zero
  always_comb begin
    word = '0;
    if (hit_idx)  word = idx_q;
    if (hit_mc)   word = MC_STAT_VAL;
    if (hit_fifo) word = FIFO_FREE_VAL;
    if (hit_cfg)  word = cfg_rdata_i;
    for (int k = 0; k < N_SCR; k++)
      if (hit_scr[k]) word = scr_q[k];
  end

  ixw_sub_word u_lane (
    .word_i  (word),
    .offs_i  (acc_addr_i[1:0]),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .rd_o    (rd_w),
    .merged_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idx_q <= '0;
    else if (acc_wr_i && hit_idx) idx_q <= merged;
  end

  assign rdata_o    = acc_rd_i ? rd_w : 32'h0;
  assign index_o    = idx_q;
  assign rf_wr_o    = acc_wr_i && (hit_idx || (|hit_scr));
  assign rf_addr_o  = wa;
  assign rf_wdata_o = merged;
  assign cfg_addr_o = wa[7:2];

  // R1
  index_word_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && acc_addr_i == 32'(A_INDEX) && size_i[1]) |=> (index_o == $past(wdata_i)));
  // R1
  index_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_wr_i && acc_addr_i[31:2] == 30'(A_INDEX >> 2)) |=> $stable(index_o));
  // R8
  mc_status_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd_i && acc_addr_i == 32'(A_MC_STAT) && size_i[1]) |-> (rdata_o == 32'd5));
  // R7
  cfg_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && acc_addr_i >= 32'(A_CFG_LO) && acc_addr_i <= 32'h0000_0FFF) |-> !rf_wr_o);
endmodule

// File: rtl/ixw_window.sv
module ixw_window
  import ixw_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 16 * 1024 * 1024,
  parameter int unsigned N_SCR     = 4,
  localparam int unsigned MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic [13:0]       addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        size_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [31:0]       rdata_o,
  output logic              rf_wr_o,
  output logic [13:0]       rf_addr_o,
  output logic [31:0]       rf_wdata_o,
  output logic [5:0]        cfg_addr_o,
  input  logic [31:0]       cfg_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  logic [RAW-1:0] eff;
  logic           win_hit, to_mem, redirect;
  logic [31:0]    index_w, acc_addr, rs_rdata, mg_rdata;

  assign eff      = io_sel_i ? {{(RAW-IO_AW){1'b0}}, addr_i[IO_AW-1:0]} : addr_i;
  assign win_hit  = {eff[RAW-1:2], 2'b00} == A_WIN;
  assign to_mem   = win_hit && index_w[31];
  assign redirect = win_hit && !index_w[31];
  // single level: a forwarded hit on the window reads back zero
  assign acc_addr = redirect ? index_w + {30'b0, eff[1:0]} : {{(32-RAW){1'b0}}, eff};

  ixw_reg_space #(.N_SCR(N_SCR)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_addr_i (acc_addr),
    .acc_rd_i   (rd_i && !to_mem),
    .acc_wr_i   (wr_i && !to_mem),
    .size_i     (size_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rs_rdata),
    .index_o    (index_w),
    .rf_wr_o    (rf_wr_o),
    .rf_addr_o  (rf_addr_o),
    .rf_wdata_o (rf_wdata_o),
    .cfg_addr_o (cfg_addr_o),
    .cfg_rdata_i(cfg_rdata_i)
  );

  ixw_mem_gate #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_rd_i   (rd_i && to_mem),
    .req_wr_i   (wr_i && to_mem),
    .ptr_i      (index_w[30:0]),
    .size_i     (size_i),
    .wdata_i    (wdata_i),
    .rdata_o    (mg_rdata),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_addr_o (mem_addr_o),
    .mem_size_o (mem_size_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  assign rdata_o = to_mem ? mg_rdata : rs_rdata;

  // R2
  mem_needs_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (index_w[31] && win_hit));
  // R2
  mem_rf_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !rf_wr_o);
  // R12
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 32'h0));
endmodule

// File: tb/ixw_window_test.sv
module ixw_window_test;
  localparam int CLK_P = 10;
  localparam int MB    = 1024;
  localparam int NS    = 4;

  logic        clk = 0, rst_n = 0;
  logic        io_sel = 0, rd = 0, wr = 0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = '0;
  logic [31:0] rdata, rf_wdata, mem_wdata, cfg_rdata;
  logic [31:0] mem_rdata;
  logic        rf_wr, mem_rd, mem_wr;
  logic [13:0] rf_addr;
  logic [5:0]  cfg_addr;
  logic [9:0]  mem_addr;
  logic [1:0]  mem_size;

  logic [7:0]  dut_mem [MB];
  logic [7:0]  ref_mem [MB];
  logic [31:0] ref_idx;
  logic [31:0] ref_scr [NS];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ixw_window #(.MEM_BYTES(MB), .N_SCR(NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .io_sel_i(io_sel), .addr_i(addr), .wdata_i(wdata),
    .size_i(size), .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .rf_wr_o(rf_wr),
    .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .cfg_addr_o(cfg_addr),
    .cfg_rdata_i(cfg_rdata), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_size_o(mem_size), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  function automatic int nb(logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mk(logic [1:0] s);
    return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign cfg_rdata = 32'hC0DE_0000 | {26'b0, cfg_addr};

  always_comb begin
    mem_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < nb(mem_size) && int'(mem_addr) + k < MB)
        mem_rdata[8*k +: 8] = dut_mem[int'(mem_addr) + k];
  end

  always @(posedge clk)
    if (mem_wr)
      for (int k = 0; k < 4; k++)
        if (k < nb(mem_size) && int'(mem_addr) + k < MB)
          dut_mem[int'(mem_addr) + k] <= mem_wdata[8*k +: 8];

  function automatic logic [31:0] reg_word(logic [31:0] a);
    logic [31:0] w;
    w = a & ~32'h3;
    if (a >= 32'h4000) return 0;
    if (w == 0) return ref_idx;
    if (w >= 32'h10 && w < 32'h10 + 4*NS) return ref_scr[(w - 32'h10) >> 2];
    if (w == 32'h150) return 5;
    if (w == 32'hE40 || w == 32'h1740) return 64;
    if (w >= 32'hF00 && w <= 32'hFFF) return 32'hC0DE_0000 | ((w - 32'hF00) >> 2);
    return 0;
  endfunction

  function automatic bit reg_writable(logic [31:0] a);
    logic [31:0] w;
    w = a & ~32'h3;
    return (a < 32'h4000) && (w == 0 || (w >= 32'h10 && w < 32'h10 + 4*NS));
  endfunction

  // kind 0 register, 1 memory
  task automatic resolve(input bit io, input logic [13:0] a, output int kind, output logic [31:0] ra);
    logic [13:0] e;
    e = io ? {6'b0, a[7:0]} : a;
    if (e[13:2] == 12'h001) begin
      if (ref_idx[31]) begin kind = 1; ra = {1'b0, ref_idx[30:0]}; end
      else begin kind = 0; ra = ref_idx + {30'b0, e[1:0]}; end
    end else begin
      kind = 0; ra = {18'b0, e};
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input bit io, input logic [13:0] a, input logic [1:0] sz,
                    input logic [31:0] d, input bit w, input string req);
    int kind;
    logic [31:0] ra, exp, old, lm, mrg;
    bit fits, wrt;
    resolve(io, a, kind, ra);
    fits = (kind == 1) && (ra + nb(sz) <= MB);
    exp = 0;
    if (kind == 1 && fits)
      for (int k = 0; k < nb(sz); k++) exp[8*k +: 8] = ref_mem[ra + k];
    else if (kind == 0)
      exp = (reg_word(ra) >> (8 * ra[1:0])) & mk(sz);
    @(negedge clk);
    io_sel = io; addr = a; size = sz; wdata = d; rd = !w; wr = w;
    #(CLK_P/4);
    if (!w) check(req, rdata, exp);
    else begin
      check(req, {31'b0, mem_wr}, {31'b0, fits});
      wrt = (kind == 0) && reg_writable(ra);
      check(req, {31'b0, rf_wr}, {31'b0, wrt});
      if (fits)
        for (int k = 0; k < nb(sz); k++) ref_mem[ra + k] = d[8*k +: 8];
      if (wrt) begin
        old = reg_word(ra);
        lm  = mk(sz) << (8 * ra[1:0]);
        mrg = (old & ~lm) | ((d << (8 * ra[1:0])) & lm);
        check(req, rf_wdata, mrg);
        check(req, {18'b0, rf_addr}, ra & ~32'h3);
        if ((ra & ~32'h3) == 0) ref_idx = mrg;
        else ref_scr[(ra - 32'h10) >> 2] = mrg;
      end
    end
    @(posedge clk); #1;
    rd = 0; wr = 0;
  endtask

  function automatic logic [31:0] rand_reg_ptr();
    case ($urandom_range(0, 4))
      0: return $urandom_range(0, 31);
      1: return 32'hF00 + $urandom_range(0, 255);
      2: return 32'h14E + $urandom_range(0, 4);
      3: return 32'h3FFC + $urandom_range(0, 7);
      default: return $urandom & 32'h7FFF_FFFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MB; i++) begin dut_mem[i] = 0; ref_mem[i] = 0; end
    ref_idx = 0;
    for (int i = 0; i < NS; i++) ref_scr[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 R11 reset values, R12 idle read data
    op(0, 14'h000, 2, 0, 0, "R1");
    op(0, 14'h01C, 2, 0, 0, "R11");
    @(negedge clk); check("R12", rdata, 32'h0);
    // R8 constants and ignored write
    op(0, 14'h150, 2, 0, 0, "R8");
    op(0, 14'h0E40, 2, 0, 0, "R8");
    op(0, 14'h1740, 2, 0, 0, "R8");
    op(0, 14'h150, 2, 32'hFFFF_FFFF, 1, "R8");
    op(0, 14'h150, 2, 0, 0, "R8");
    // R1 index round trip
    op(0, 14'h000, 2, 32'hDEAD_BEEF, 1, "R1");
    op(0, 14'h000, 2, 0, 0, "R1");
    // R6 lane merges
    op(0, 14'h014, 2, 32'h1122_3344, 1, "R6");
    op(0, 14'h016, 0, 32'h0000_00AA, 1, "R6");
    op(0, 14'h014, 2, 0, 0, "R6");
    op(0, 14'h017, 1, 0, 0, "R6");
    op(0, 14'h017, 1, 32'h0000_BBCC, 1, "R6");
    op(0, 14'h014, 2, 0, 0, "R6");
    // R2 memory, offset ignored
    op(0, 14'h000, 2, 32'h8000_0100, 1, "R2");
    op(0, 14'h006, 2, 32'hA1B2_C3D4, 1, "R2");
    op(0, 14'h000, 2, 32'h8000_0101, 1, "R2");
    op(0, 14'h004, 0, 0, 0, "R2");
    op(0, 14'h005, 1, 0, 0, "R2");
    // R3 bounds
    op(0, 14'h000, 2, 32'h8000_03FC, 1, "R3");
    op(0, 14'h004, 2, 32'h5566_7788, 1, "R3");
    op(0, 14'h004, 2, 0, 0, "R3");
    op(0, 14'h000, 2, 32'h8000_03FD, 1, "R3");
    op(0, 14'h004, 2, 32'h1, 1, "R3");
    op(0, 14'h004, 2, 0, 0, "R3");
    op(0, 14'h000, 2, 32'h8000_03FF, 1, "R3");
    op(0, 14'h004, 0, 0, 0, "R3");
    // R4 forwarding
    op(0, 14'h000, 2, 32'h0000_0010, 1, "R4");
    op(0, 14'h004, 2, 32'hCAFE_F00D, 1, "R4");
    op(0, 14'h010, 2, 0, 0, "R4");
    op(0, 14'h000, 2, 32'h0000_000E, 1, "R4");
    op(0, 14'h006, 2, 0, 0, "R4");
    // R5 one level, out of space
    op(0, 14'h000, 2, 32'h0000_0002, 1, "R5");
    op(0, 14'h007, 0, 0, 0, "R5");
    op(0, 14'h007, 0, 32'h77, 1, "R5");
    op(0, 14'h000, 2, 32'h0000_3FFF, 1, "R5");
    op(0, 14'h005, 0, 0, 0, "R5");
    // R7 configuration mirror
    op(0, 14'h0F40, 2, 0, 0, "R7");
    op(0, 14'h0F40, 2, 32'h1234_5678, 1, "R7");
    op(0, 14'h0F42, 1, 0, 0, "R7");
    // R10 unmapped
    op(0, 14'h0200, 2, 32'hFFFF_FFFF, 1, "R10");
    op(0, 14'h0200, 2, 0, 0, "R10");
    // R9 alias
    op(1, 14'h0110, 2, 0, 0, "R9");
    op(0, 14'h0110, 2, 0, 0, "R9");
    op(1, 14'h3F18, 2, 32'h0BAD_CAFE, 1, "R9");
    op(0, 14'h0018, 2, 0, 0, "R9");

    for (int n = 0; n < 4000; n++) begin
      case ($urandom_range(0, 9))
        0, 1: begin
          if ($urandom_range(0, 1) == 1) p = 32'h8000_0000 | (($urandom_range(0, 7) == 0) ?
                                             $urandom : 32'($urandom_range(0, 1030)));
          else p = rand_reg_ptr();
          op(0, 14'h000, 2, p, 1, "R1");
        end
        2, 3, 4: op($urandom_range(0, 1), 14'h004 | 14'($urandom_range(0, 3)),
                    2'($urandom_range(0, 3)), $urandom, $urandom_range(0, 1), "R2");
        5: op(0, 14'h010 | 14'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
              $urandom, $urandom_range(0, 1), "R6");
        6: op(0, 14'(rand_reg_ptr()), 2'($urandom_range(0, 3)), $urandom,
              $urandom_range(0, 1), "R10");
        7: op(0, 14'h000 | 14'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 0, 0, "R1");
        8: op(1, 14'($urandom), 2'($urandom_range(0, 3)), $urandom,
              $urandom_range(0, 1), "R9");
        default: op(0, 14'h004 | 14'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    0, 0, "R4");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule